// File: doc/BRIEF.md
# Dominant-Zero Serial Bus Byte Engine

This block moves single bytes over a shared one-wire-level serial bus on which any node that pulls low wins over any node that lets go. Each byte carries asynchronous UART framing. The block has one output that pulls the bus low and one input that reads back the resolved bus level. Transmit and receive both run from a single clock-enable tick. A small divider makes that tick from the block clock, and a two-bit strap code sets the division ratio.

A host hands over a byte when the block shows it is ready. The block frames the byte and pulls the bus low for every zero bit. While it transmits, it also receives, so the byte that actually appeared on the bus comes back to the host through the normal receive path. At the mid-bit sample of every bit it compares the level it sent with the level it reads back. If they differ, another node has won arbitration. The block then releases the bus and refuses new bytes until an end-of-message pulse arrives from the idle detector outside the block.

On receive, the block realigns to each start-bit falling edge. It samples in the middle of each bit and rejects start bits that do not last. A stop bit read as zero is a framing error, and it silences byte delivery until the next end-of-message pulse. A break input pulls the bus low for as long as it is held. A busy indication marks the data portion of each byte seen on the bus.

Top module: `sbe_bus_engine`

## Requirements
- R1: A transmitted byte appears on `bus_drive_low` as ten bit cells: a start cell with the output at 1, then the eight data bits least significant first, then a stop cell with the output at 0. The output is 1 exactly for cells whose bit value is 0.
- R2: One bit cell lasts BIT_TICKS (128) divider ticks. With divide code 00 a tick occurs every clock, so a cell lasts 128 clocks.
- R3: `div_sel` sets the tick rate. Code 00 divides the clock by 1, 01 by 2, 10 by 4 and 11 by 10. A bit cell therefore lasts 128×ratio clocks, less at most ratio−1 clocks of phase uncertainty at the start of a frame.
- R4: A frame on `bus_in` with a valid start bit and a stop bit of 1 produces a one-clock pulse on `rx_valid`. `rx_data` then holds the eight data bits, with the first received bit in bit 0.
- R5: While the block transmits, the byte delivered on `rx_data` is the byte resolved on the bus, not the byte that was loaded.
- R6: When a transmitted bit differs from the bus level sampled at that bit's middle, `bus_drive_low` drops to 0 on the next clock. It stays 0 for the rest of the frame, and `tx_ready` stays 0, until `eom` pulses.
- R7: A node whose bits all match the bus keeps driving its remaining zero bits and returns to ready at the end of the frame.
- R8: A received stop bit of 0 suppresses `rx_valid` for that frame and for every later frame until `eom` pulses. After the pulse, reception resumes.
- R9: A low level on `bus_in` that is gone again at the middle of the start cell is discarded, and no byte is delivered.
- R10: While `brk_n` is 0, `bus_drive_low` is 1 continuously. When `brk_n` returns to 1, the forced low ends.
- R11: `busy_n` falls at the start of the first data bit of a byte seen on the bus and rises at the middle of the last data bit.
- R12: After reset, `bus_drive_low` is 0, `tx_ready` is 1, `rx_valid` is 0 and `busy_n` is 1.
- R13: A byte is taken only on a clock where both `tx_valid` and `tx_ready` are 1. A request made while a frame is in progress, or while the block is blocked, is dropped and leaves the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Tick divide code (00 /1, 01 /2, 10 /4, 11 /10) |
| bus_in | input | 1 | Resolved bus level, 1 = released |
| bus_drive_low | output | 1 | 1 pulls the bus low |
| brk_n | input | 1 | Active-low break request |
| eom | input | 1 | End-of-message pulse; clears blocking and framing lockout |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block accepts a byte this clock |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_data | output | 8 | Received or reflected byte |
| busy_n | output | 1 | Low during the data portion of a byte on the bus |

## Verification
The bench builds the block with its default parameters: a bit cell of 128 ticks and a two-stage synchronizer. It keeps `div_sel` at 00 for most of the run, so each frame lasts 1280 clocks. That setting lets the bench cover transmit, receive, a lost and a won arbitration, framing lockout, false starts, break and busy timing in a short run. The bench also steps through all four divide codes once, which puts the longest frame, 12800 clocks, within reach, and it measures the start cell against each ratio.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = 10;
    localparam int MAX_DIV    = 10;

    typedef enum logic [1:0] {
        DIV_BY_1  = 2'b00,
        DIV_BY_2  = 2'b01,
        DIV_BY_4  = 2'b10,
        DIV_BY_10 = 2'b11
    } div_code_e;

    typedef enum logic {
        LINE_IDLE  = 1'b0,
        LINE_FRAME = 1'b1
    } line_state_e;

    typedef struct packed {
        logic [3:0]            pos;
        logic [FRAME_BITS-1:0] bits;
    } tx_frame_t;

    function automatic int unsigned div_ratio(input logic [1:0] code);
        int unsigned r;
        case (div_code_e'(code))
            DIV_BY_1:  r = 1;
            DIV_BY_2:  r = 2;
            DIV_BY_4:  r = 4;
            default:   r = 10;
        endcase
        return r;
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_of(input logic [DATA_BITS-1:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/sbe_tick_gen.sv
module sbe_tick_gen
    import sbe_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] limit;

    always_comb limit = DIV_W'(div_ratio(div_sel) - 1);

    assign tick = (dcnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       dcnt <= '0;
        else if (tick) dcnt <= '0;
        else           dcnt <= dcnt + 1'b1;
    end

    // R3
    tick_space_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != 2'b00) |=> (!tick || div_sel != $past(div_sel)));

endmodule

// File: rtl/sbe_sync.sv
module sbe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], din};
    end

    assign dout = ff[STAGES-1];

endmodule

// File: rtl/sbe_tx.sv
module sbe_tx
    import sbe_pkg::*;
#(
    parameter int BIT_TICKS = 128,
    parameter int CNT_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 bus_s,
    input  logic                 eom,
    input  logic                 load_valid,
    input  logic [DATA_BITS-1:0] load_data,
    output logic                 ready,
    output logic                 drive
);

    localparam int SAMPLE_AT = BIT_TICKS / 2;
    localparam int LAST_TICK = BIT_TICKS - 1;

    tx_frame_t        fr;
    logic             active;
    logic             blocked;
    logic [CNT_W-1:0] cnt;
    logic             cur_bit;
    logic             at_mid;
    logic             at_end;

    assign cur_bit = fr.bits[fr.pos];
    assign at_mid  = tick && (cnt == CNT_W'(SAMPLE_AT));
    assign at_end  = tick && (cnt == CNT_W'(LAST_TICK));
    assign ready   = !active && !blocked;
    assign drive   = active && !cur_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr      <= '0;
            active  <= 1'b0;
            blocked <= 1'b0;
            cnt     <= '0;
        end else begin
            if (eom) blocked <= 1'b0;
            if (!active) begin
                if (load_valid && ready) begin
                    active  <= 1'b1;
                    fr.bits <= frame_of(load_data);
                    fr.pos  <= 4'd0;
                    cnt     <= '0;
                end
            end else begin
                if (tick) cnt <= at_end ? '0 : cnt + 1'b1;
                if (at_mid && (cur_bit != bus_s)) begin
                    active  <= 1'b0;
                    blocked <= 1'b1;
                end else if (at_end) begin
                    if (fr.pos == 4'(FRAME_BITS - 1)) active <= 1'b0;
                    else                               fr.pos <= fr.pos + 1'b1;
                end
            end
        end
    end

    // R6
    cut_off_chk: assert property (@(posedge clk) disable iff (rst)
        (active && at_mid && (cur_bit != bus_s)) |=> !drive);

    // R6
    block_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked && !eom) |=> (blocked && !drive));

endmodule

// File: rtl/sbe_rx.sv
module sbe_rx
    import sbe_pkg::*;
#(
    parameter int BIT_TICKS = 128,
    parameter int CNT_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 bus_s,
    input  logic                 eom,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 busy
);

    localparam int SAMPLE_AT = BIT_TICKS / 2;
    localparam int LAST_TICK = BIT_TICKS - 1;

    line_state_e          state;
    logic [CNT_W-1:0]     cnt;
    logic [3:0]           pos;
    logic [DATA_BITS-1:0] shreg;
    logic                 prev;
    logic                 lock;
    logic                 fall;
    logic                 at_mid;
    logic                 at_end;

    assign fall   = prev && !bus_s;
    assign at_mid = tick && (cnt == CNT_W'(SAMPLE_AT));
    assign at_end = tick && (cnt == CNT_W'(LAST_TICK));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LINE_IDLE;
            cnt        <= '0;
            pos        <= '0;
            shreg      <= '0;
            prev       <= 1'b1;
            lock       <= 1'b0;
            busy       <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            prev       <= bus_s;
            byte_valid <= 1'b0;
            if (eom) lock <= 1'b0;
            case (state)
                LINE_IDLE: begin
                    if (fall) begin
                        state <= LINE_FRAME;
                        cnt   <= '0;
                        pos   <= '0;
                    end
                end
                default: begin
                    if (tick) cnt <= at_end ? '0 : cnt + 1'b1;
                    if (at_end) begin
                        pos <= pos + 1'b1;
                        if (pos == 4'd0) busy <= 1'b1;
                    end
                    if (at_mid) begin
                        if (pos == 4'd0) begin
                            if (bus_s) state <= LINE_IDLE;
                        end else if (pos <= 4'(DATA_BITS)) begin
                            shreg <= {bus_s, shreg[DATA_BITS-1:1]};
                            if (pos == 4'(DATA_BITS)) busy <= 1'b0;
                        end else begin
                            state <= LINE_IDLE;
                            if (bus_s && !lock) begin
                                byte_valid <= 1'b1;
                                byte_data  <= shreg;
                            end else if (!bus_s) begin
                                lock <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !eom) |=> lock);

    // R8
    lock_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !eom) |=> !byte_valid);

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R11
    busy_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (state == LINE_FRAME));

endmodule

// File: rtl/sbe_bus_engine.sv
module sbe_bus_engine
    import sbe_pkg::*;
#(
    parameter int BIT_TICKS   = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       bus_in,
    output logic       bus_drive_low,
    input  logic       brk_n,
    input  logic       eom,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       busy_n
);

    localparam int CNT_W = $clog2(BIT_TICKS);
    localparam int DIV_W = $clog2(MAX_DIV);

    logic tick;
    logic bus_s;
    logic tx_drive;
    logic rx_busy;

    sbe_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    sbe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (bus_in),
        .dout (bus_s)
    );

    sbe_tx #(.BIT_TICKS(BIT_TICKS), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .bus_s      (bus_s),
        .eom        (eom),
        .load_valid (tx_valid),
        .load_data  (tx_data),
        .ready      (tx_ready),
        .drive      (tx_drive)
    );

    sbe_rx #(.BIT_TICKS(BIT_TICKS), .CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .bus_s      (bus_s),
        .eom        (eom),
        .byte_valid (rx_valid),
        .byte_data  (rx_data),
        .busy       (rx_busy)
    );

    assign bus_drive_low = tx_drive || !brk_n;
    assign busy_n        = !rx_busy;

endmodule

// File: tb/sbe_bus_engine_tb.sv
module sbe_bus_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       bus_in;
    logic       bus_drive_low;
    logic       brk_n = 1'b1;
    logic       eom = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       busy_n;
    logic       remote_n = 1'b1;

    int total = 0;
    int bad = 0;
    int rx_seen = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    assign bus_in = !bus_drive_low && remote_n;

    sbe_bus_engine u_dut (
        .clk           (clk),
        .rst           (rst),
        .div_sel       (div_sel),
        .bus_in        (bus_in),
        .bus_drive_low (bus_drive_low),
        .brk_n         (brk_n),
        .eom           (eom),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_ready      (tx_ready),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .busy_n        (busy_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    function automatic logic [9:0] frame_bits(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    task automatic remote_send(input logic [9:0] fr, input int bit_clks);
        for (int i = 0; i < 10; i++) begin
            remote_n = fr[i];
            step(bit_clks);
        end
        remote_n = 1'b1;
    endtask

    task automatic pulse_eom();
        eom = 1'b1;
        step(1);
        eom = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_seen++;
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R8 unexpected byte delivered: actual=%0h expected=none", rx_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_data == e, t, "delivered byte", rx_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seen0;
        int n;
        logic [9:0] fr;

        step(5);
        rst = 1'b0;
        step(2);

        // R12 reset state
        check(bus_drive_low == 1'b0, "R12", "drive after reset", bus_drive_low, 0);
        check(tx_ready == 1'b1, "R12", "ready after reset", tx_ready, 1);
        check(rx_valid == 1'b0, "R12", "rx_valid after reset", rx_valid, 0);
        check(busy_n == 1'b1, "R12", "busy_n after reset", busy_n, 1);

        // R1 / R5 / R13: send 0xA5 alone, reflected byte comes back
        expect_byte(8'hA5, "R5");
        fr = frame_bits(8'hA5);
        tx_data = 8'hA5;
        tx_valid = 1'b1;
        step(1);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R13", "ready during frame", tx_ready, 0);
        for (int k = 0; k < 10; k++) begin
            step(64);
            check(bus_drive_low == !fr[k], "R1", $sformatf("cell %0d level", k),
                  bus_drive_low, !fr[k]);
            if (k == 3) begin
                tx_data = 8'h00;
                tx_valid = 1'b1;
                step(1);
                tx_valid = 1'b0;
                step(63);
            end else begin
                step(64);
            end
        end
        step(10);
        check(tx_ready == 1'b1, "R13", "ready after frame", tx_ready, 1);
        check(bus_drive_low == 1'b0, "R13", "dropped request left bus idle", bus_drive_low, 0);

        // R4: remote byte received
        expect_byte(8'h3C, "R4");
        remote_send(frame_bits(8'h3C), 128);
        step(100);

        // R11: busy timing on a remote byte
        expect_byte(8'h5A, "R11");
        fork
            remote_send(frame_bits(8'h5A), 128);
            begin
                step(64);
                check(busy_n == 1'b1, "R11", "busy_n in start cell", busy_n, 1);
                step(56);
                check(busy_n == 1'b1, "R11", "busy_n end of start cell", busy_n, 1);
                step(72);
                check(busy_n == 1'b0, "R11", "busy_n first data bit", busy_n, 0);
                step(8 * 128 + 40 - 192);
                check(busy_n == 1'b0, "R11", "busy_n early last data bit", busy_n, 0);
                step(70);
                check(busy_n == 1'b1, "R11", "busy_n late last data bit", busy_n, 1);
            end
        join
        step(100);

        // R2 / R3: start cell length for every divide code
        for (int code = 0; code < 4; code++) begin
            int ratio;
            ratio = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 10;
            div_sel = code[1:0];
            step(20);
            expect_byte(8'hFF, "R3");
            tx_data = 8'hFF;
            tx_valid = 1'b1;
            step(1);
            tx_valid = 1'b0;
            n = 0;
            while (bus_drive_low) begin
                n++;
                step(1);
            end
            if (code == 0)
                check(n == 128, "R2", "start cell clocks at ratio 1", n, 128);
            else
                check(n <= 128 * ratio && n > 127 * ratio, "R3",
                      $sformatf("start cell clocks code %0d", code), n, 128 * ratio);
            while (!tx_ready) step(1);
            step(50);
        end
        div_sel = 2'b00;
        step(20);

        // R6: lose arbitration (send 0x03 against remote 0x01)
        expect_byte(8'h01, "R6");
        tx_data = 8'h03;
        tx_valid = 1'b1;
        fork
            remote_send(frame_bits(8'h01), 128);
            begin
                step(1);
                tx_valid = 1'b0;
                step(2 * 128 + 74);
                check(bus_drive_low == 1'b0, "R6", "drive after mismatch", bus_drive_low, 0);
                check(tx_ready == 1'b0, "R6", "ready after mismatch", tx_ready, 0);
                step(3 * 128);
                check(bus_drive_low == 1'b0, "R6", "drive on later zero bit", bus_drive_low, 0);
            end
        join
        step(100);
        tx_data = 8'h00;
        tx_valid = 1'b1;
        step(1);
        tx_valid = 1'b0;
        step(64);
        check(bus_drive_low == 1'b0, "R13", "request while blocked", bus_drive_low, 0);
        step(200);
        check(tx_ready == 1'b0, "R6", "still blocked before eom", tx_ready, 0);
        pulse_eom();
        check(tx_ready == 1'b1, "R6", "ready after eom", tx_ready, 1);
        step(20);

        // R7: win arbitration (send 0x01 against remote 0x03)
        expect_byte(8'h01, "R7");
        tx_data = 8'h01;
        tx_valid = 1'b1;
        fork
            remote_send(frame_bits(8'h03), 128);
            begin
                step(1);
                tx_valid = 1'b0;
                step(6 * 128 + 64);
                check(bus_drive_low == 1'b1, "R7", "winner drives data bit 5", bus_drive_low, 1);
            end
        join
        step(100);
        check(tx_ready == 1'b1, "R7", "winner ready after frame", tx_ready, 1);

        // R9: false start rejected
        seen0 = rx_seen;
        remote_n = 1'b0;
        step(20);
        remote_n = 1'b1;
        step(300);
        check(rx_seen == seen0, "R9", "bytes after glitch", rx_seen, seen0);
        check(busy_n == 1'b1, "R9", "busy_n after glitch", busy_n, 1);
        expect_byte(8'h96, "R9");
        remote_send(frame_bits(8'h96), 128);
        step(100);

        // R8: framing error locks reception until eom
        seen0 = rx_seen;
        remote_send({1'b0, 8'h55, 1'b0}, 128);
        step(50);
        check(rx_seen == seen0, "R8", "bytes after bad stop", rx_seen, seen0);
        remote_send(frame_bits(8'h42), 128);
        step(100);
        check(rx_seen == seen0, "R8", "bytes while locked", rx_seen, seen0);
        pulse_eom();
        expect_byte(8'h24, "R8");
        remote_send(frame_bits(8'h24), 128);
        step(100);
        check(rx_seen == seen0 + 1, "R8", "bytes after eom", rx_seen, seen0 + 1);

        // R10: break
        brk_n = 1'b0;
        step(1);
        check(bus_drive_low == 1'b1, "R10", "drive at break start", bus_drive_low, 1);
        step(700);
        check(bus_drive_low == 1'b1, "R10", "drive mid break", bus_drive_low, 1);
        step(800);
        check(bus_drive_low == 1'b1, "R10", "drive late break", bus_drive_low, 1);
        brk_n = 1'b1;
        step(2);
        check(bus_drive_low == 1'b0, "R10", "drive after break", bus_drive_low, 0);
        step(50);
        pulse_eom();
        expect_byte(8'h77, "R10");
        remote_send(frame_bits(8'h77), 128);
        step(100);

        check(exp_q.size() == 0, "R4", "pending expected bytes", exp_q.size(), 0);
        finish_run();
    end

endmodule